// File: doc/BRIEF.md
# Two-Read-Port Register File with Same-Cycle Write Forwarding

This block holds thirty-two general registers for a short in-order pipeline. Two operands can be read combinationally in the same cycle, and one register can be written on each clock edge. Register 0 is hard-wired: it always reads as zero, and writes to it are discarded.

A build-time switch chooses how a read relates to a write in the same cycle. In forwarding mode, the write comes first. A read whose index matches the register being written returns the incoming data at once, on either port. This lets a decode stage consume a result that the execute stage is writing back in that cycle, with no stall. In plain mode, the read comes first. The read returns the value held before the edge, and the new value appears one cycle later.

Top module: `bprf_top`

## Requirements
- R1: After reset, every register from 0 to 31 reads as zero on both read ports.
- R2: A read of index 0 returns zero in every cycle, even when a write to index 0 is presented in the same cycle. A write to index 0 never changes what index 0 reads.
- R3: In forwarding mode (BYPASS=1), when `wr_en` is 1 and `rd_idx_a` equals a non-zero `wr_idx`, `rd_data_a` returns `wr_data` in that same cycle.
- R4: In forwarding mode, the same same-cycle forwarding applies to `rd_idx_b` and `rd_data_b`.
- R5: In plain mode (BYPASS=0), a read of the index being written returns the value held before the clock edge on both ports.
- R6: In both modes, a write to a non-zero index with `wr_en` at 1 is returned by reads of that index in every cycle after the edge, until another write to that index occurs.
- R7: A read whose index differs from the index being written returns the stored value and is not affected by the concurrent write.
- R8: When `wr_en` is 0, no register changes and nothing is forwarded, whatever `wr_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | IDX_W (5) | Register written |
| wr_data | input | DATA_W (32) | Data written |
| rd_idx_a | input | IDX_W (5) | Register read on port A |
| rd_data_a | output | DATA_W (32) | Combinational data for port A |
| rd_idx_b | input | IDX_W (5) | Register read on port B |
| rd_data_b | output | DATA_W (32) | Combinational data for port B |

## Verification
The assertions assume the write controls are never unknown while reset is released. They also assume every index stays below the register count, which holds by construction for the default of 32 entries and a 5-bit index. The bench changes inputs only just after a rising edge, so each combinational read is sampled in the same cycle as the write it may see. Random patterns are steered so that about half of the reads hit the index being written, and index 0 appears often as both a write target and a read target. A reference array kept in the bench predicts both a forwarding instance and a plain instance, which are driven with identical inputs.

// File: rtl/bprf_pkg.sv
package bprf_pkg;

  // Read ordering relative to a same-cycle write
  typedef enum logic {
    RD_PLAIN   = 1'b0,
    RD_FORWARD = 1'b1
  } rd_order_e;

  // True when a live write targets the non-zero register being read
  function automatic logic live_hit(input logic en, input int unsigned widx,
                                    input int unsigned ridx);
    return en && (widx == ridx) && (ridx != 0);
  endfunction

endpackage

// File: rtl/bprf_storage.sv
module bprf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  logic [NUM_REGS-1:0] ent_we;

  // next-state: per-entry write enables
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      ent_we[i] = wr_en && (wr_idx == IDX_W'(i)) && (i != 0);
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
      if (g == 0) begin : g_zero
        assign regs_q[g] = '0;
      end else begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q <= '0;
          end else if (ent_we[g]) begin
            q <= wr_data;
          end
        end
        assign regs_q[g] = q;
      end
    end
  endgenerate

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> regs_q[$past(wr_idx)] == $past(wr_data));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(regs_q));

endmodule

// File: rtl/bprf_rd_port.sv
module bprf_rd_port
  import bprf_pkg::*;
#(
  parameter int        DATA_W   = 32,
  parameter int        NUM_REGS = 32,
  parameter int        IDX_W    = $clog2(NUM_REGS),
  parameter rd_order_e ORDER    = RD_FORWARD
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [IDX_W-1:0]                 rd_idx,
  output logic [DATA_W-1:0]                rd_data
);

  logic              fwd_hit;
  logic [DATA_W-1:0] arr_val;

  always_comb begin
    arr_val = regs_q[rd_idx];
    fwd_hit = (ORDER == RD_FORWARD) &&
              live_hit(wr_en, int'(unsigned'(wr_idx)), int'(unsigned'(rd_idx)));
    if (rd_idx == '0) begin
      rd_data = '0;
    end else if (fwd_hit) begin
      rd_data = wr_data;
    end else begin
      rd_data = arr_val;
    end
  end

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0));

  // R3
  fwd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ORDER == RD_FORWARD && wr_en && wr_idx == rd_idx && rd_idx != '0)
      |-> (rd_data == wr_data));

  // R7
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx != '0 && !(wr_en && wr_idx == rd_idx)) |-> (rd_data == regs_q[rd_idx]));

endmodule

// File: rtl/bprf_top.sv
module bprf_top
  import bprf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter bit BYPASS   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int        NUM_RD = 2;
  localparam rd_order_e ORDER  = BYPASS ? RD_FORWARD : RD_PLAIN;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  assign rd_idx[0] = rd_idx_a;
  assign rd_idx[1] = rd_idx_b;
  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  bprf_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      bprf_rd_port #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .ORDER    (ORDER)
      ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs_q  (regs_q),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx[p]),
        .rd_data (rd_data[p])
      );
    end
  endgenerate

  // R4
  port_b_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BYPASS && wr_en && wr_idx == rd_idx_b && rd_idx_b != '0) |-> (rd_data_b == wr_data));

  // R5
  plain_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!BYPASS && wr_en && wr_idx == rd_idx_a && rd_idx_a != '0) |=>
      (rd_idx_a != $past(rd_idx_a) || wr_en || rd_data_a == $past(wr_data)));

endmodule

// File: tb/tb_bprf_top.sv
module tb_bprf_top;

  localparam int DW = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx_a, rd_idx_b;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] fa, fb, pa, pb;

  always #5 clk = ~clk;

  bprf_top #(.DATA_W(DW), .NUM_REGS(32), .BYPASS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(fa), .rd_idx_b(rd_idx_b), .rd_data_b(fb));

  bprf_top #(.DATA_W(DW), .NUM_REGS(32), .BYPASS(1'b0)) dut_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(pa), .rd_idx_b(rd_idx_b), .rd_data_b(pb));

  typedef struct {
    logic [DW-1:0] fa;
    logic [DW-1:0] fb;
    logic [DW-1:0] pa;
    logic [DW-1:0] pb;
  } exp_t;

  exp_t          exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] refm [32];
  int            n_cmp  = 0;
  int            n_fail = 0;
  bit            done   = 1'b0;

  function automatic logic [DW-1:0] predict(input bit fwd, input logic we,
      input logic [IW-1:0] wi, input logic [DW-1:0] wd, input logic [IW-1:0] ri);
    if (ri == '0) return '0;
    if (fwd && we && wi == ri) return wd;
    return refm[ri];
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected reads
  task automatic step(input logic we, input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                      input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string tag);
    exp_t e;
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx_a = ra; rd_idx_b = rb;
    e.fa = predict(1'b1, we, wi, wd, ra);
    e.fb = predict(1'b1, we, wi, wd, rb);
    e.pa = predict(1'b0, we, wi, wd, ra);
    e.pb = predict(1'b0, we, wi, wd, rb);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    if (we && wi != '0) refm[wi] = wd;
    #1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "fwd port A", fa, e.fa);
      cmp(t, "fwd port B", fb, e.fb);
      cmp(t, "plain port A", pa, e.pa);
      cmp(t, "plain port B", pb, e.pb);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) refm[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx_a = '0; rd_idx_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset contents
    for (int i = 0; i < 32; i++) step(1'b0, '0, '0, IW'(i), IW'(31 - i), "R1");

    // R8: disabled write changes nothing and forwards nothing
    step(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5, "R8");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, "R8");

    // R3/R4/R5: same-cycle write and read of one index
    step(1'b1, 5'd7, 32'hA5A5_0007, 5'd7, 5'd7, "R3/R4/R5");
    // R6: visible after the edge in both modes
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd7, "R6");
    // R5: overwrite shows old value only in plain mode
    step(1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd3, "R5");
    step(1'b0, 5'd0, 32'h0, 5'd3, 5'd7, "R6");

    // R7: different indices untouched by the concurrent write
    step(1'b1, 5'd9, 32'h0000_0909, 5'd3, 5'd10, "R7");
    step(1'b1, 5'd10, 32'hCAFE_0010, 5'd9, 5'd11, "R7");

    // R2: index 0 ignores writes and always reads zero
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R2");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd9, "R2");

    // R3/R4/R7: random mix, half of reads hit the written index
    for (int k = 0; k < 400; k++) begin
      logic [IW-1:0] wi, ra, rb;
      wi = IW'($urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) wi = '0;
      ra = ($urandom_range(0, 1) == 1) ? wi : IW'($urandom_range(0, 31));
      rb = ($urandom_range(0, 1) == 1) ? wi : IW'($urandom_range(0, 31));
      step(1'($urandom_range(0, 3) != 0), wi, $urandom(), ra, rb, "R3/R4/R7");
    end

    // R6: final sweep of every register in both modes
    for (int i = 0; i < 32; i++) step(1'b0, '0, '0, IW'(i), IW'(i), "R6");

    @(negedge clk); #1;
    finish_run();
  end

endmodule